// File: doc/BRIEF.md
# Masked Address Breakpoint Comparator

This block watches a processor bus and raises a break interrupt request when a bus access hits a programmed 32-bit break address. Any address bit whose mask bit is set is left out of the comparison, so one break address can cover an aligned window or a scattered set of addresses. A two-bit cycle-select field decides which bus masters may trigger a break: none, the CPU only, the data-transfer controller only, or both.

Software programs the block through a synchronous 16-bit register port. The break address and the mask each occupy two 16-bit halves, high and low. A control register holds the cycle select, and a status register exposes a sticky break flag that software clears by writing 1. The interrupt output is the sticky flag.

The flag is driven by a three-state machine. **ST_OFF** means the cycle select is 00 and no flag is held. **ST_WATCH** means a break is enabled and no flag is held. **ST_HELD** means the flag is set and the interrupt is asserted. The transitions are:
- OFF→WATCH when the select becomes nonzero.
- WATCH→OFF when the select returns to 00.
- OFF/WATCH→HELD on a qualifying hit.
- HELD→WATCH or HELD→OFF on a write-1 clear with no hit in the same cycle. The select value picks which of the two.
- HELD→HELD on a hit, or when no clear is written.

Top module: `brk_unit`

## Requirements
- R1: After reset, all six registers read 0 and `brk_irq` is low. The register select values are: 0 address high, 1 address low, 2 mask high, 3 mask low, 4 cycle control, 5 status. Selects 6 and 7 read 0.
- R2: The address halves are read/write. A write takes effect at the clock edge where `reg_we` is high, and the new value is visible on `reg_rdata` afterwards.
- R3: Mask bit n = 0 makes address bit n take part in the compare. Mask bit n = 1 leaves bit n out. The mask high half holds bits 31..16 and the low half holds bits 15..0. After reset every bit is compared.
- R4: In the cycle control register only bits 7..6 are stored, as the cycle select. All other bits read 0.
- R5: With cycle select 00, no break is raised.
- R6: Cycle select 01 breaks only on CPU accesses (`bus_master` = 0).
- R7: Cycle select 10 breaks only on transfer-controller accesses (`bus_master` = 1).
- R8: Cycle select 11 breaks on accesses from either master.
- R9: Bus inputs are considered only at edges where `bus_valid` is high.
- R10: `brk_irq` rises at the clock edge that samples the matching access. It is low during that access cycle and high in the cycle after it.
- R11: The flag is sticky. Status bit 0 reads the flag. Writing status with bit 0 = 1 clears it, and writing bit 0 = 0 has no effect.
- R12: When a qualifying hit and a clear write meet at the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_sel`) |
| bus_valid | input | 1 | Bus access strobe |
| bus_addr | input | 32 | Bus access address |
| bus_master | input | 1 | 0 = CPU, 1 = transfer controller |
| brk_irq | output | 1 | Sticky break interrupt request |

## Verification
A register write lands at the edge where it is issued, and its readback is combinational. The bench therefore drives each write at a falling edge and reads the register at the next falling edge. The break flag sits one register behind the bus, so after each access the bench checks `brk_irq` low just before the sampling edge and at the value the requirements predict at the falling edge that follows. Simultaneous clear and hit are driven at the same falling edge, and the result is checked one half-cycle after the shared rising edge.

// File: rtl/brkcmp_pkg.sv
package brkcmp_pkg;

    typedef enum logic [2:0] {
        SEL_ADDR_HI = 3'd0,
        SEL_ADDR_LO = 3'd1,
        SEL_MASK_HI = 3'd2,
        SEL_MASK_LO = 3'd3,
        SEL_CYCLE   = 3'd4,
        SEL_STATUS  = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        CYC_NONE = 2'b00,
        CYC_CPU  = 2'b01,
        CYC_XFER = 2'b10,
        CYC_BOTH = 2'b11
    } cyc_sel_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_HELD  = 2'd2
    } brk_state_e;

    localparam int unsigned CYC_LSB  = 6;
    localparam int unsigned CLR_BIT  = 0;
    localparam logic        MST_CPU  = 1'b0;
    localparam logic        MST_XFER = 1'b1;

endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
    import brkcmp_pkg::*;
#(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              flag_q,
    output logic [ADDR_W-1:0] brk_addr,
    output logic [ADDR_W-1:0] brk_mask,
    output cyc_sel_e          cyc_sel,
    output logic              clr_req
);
    localparam int unsigned HALVES = ADDR_W / REG_W;

    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(reg_sel);

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            localparam reg_sel_e A_SEL = (h == HALVES - 1) ? SEL_ADDR_HI : SEL_ADDR_LO;
            localparam reg_sel_e M_SEL = (h == HALVES - 1) ? SEL_MASK_HI : SEL_MASK_LO;
            logic [REG_W-1:0] a_q;
            logic [REG_W-1:0] m_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    a_q <= '0;
                    m_q <= '0;
                end else if (reg_we) begin
                    if (sel_e == A_SEL) a_q <= reg_wdata;
                    if (sel_e == M_SEL) m_q <= reg_wdata;
                end
            end

            assign brk_addr[h*REG_W +: REG_W] = a_q;
            assign brk_mask[h*REG_W +: REG_W] = m_q;
        end
    endgenerate

    cyc_sel_e cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= CYC_NONE;
        end else if (reg_we && sel_e == SEL_CYCLE) begin
            cyc_q <= cyc_sel_e'(reg_wdata[CYC_LSB +: 2]);
        end
    end

    assign cyc_sel = cyc_q;
    assign clr_req = reg_we && (sel_e == SEL_STATUS) && reg_wdata[CLR_BIT];

    always_comb begin
        reg_rdata = '0;
        case (sel_e)
            SEL_ADDR_HI: reg_rdata = brk_addr[ADDR_W-1 -: REG_W];
            SEL_ADDR_LO: reg_rdata = brk_addr[REG_W-1:0];
            SEL_MASK_HI: reg_rdata = brk_mask[ADDR_W-1 -: REG_W];
            SEL_MASK_LO: reg_rdata = brk_mask[REG_W-1:0];
            SEL_CYCLE:   reg_rdata[CYC_LSB +: 2] = cyc_q;
            SEL_STATUS:  reg_rdata[CLR_BIT] = flag_q;
            default:     reg_rdata = '0;
        endcase
    end

    // R4: a write to the cycle register is visible as the select one edge later
    a_r4_cycle_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel_e == SEL_CYCLE) |=> (cyc_sel == cyc_sel_e'($past(reg_wdata[CYC_LSB +: 2]))));

    // R2: a write to the low address half is seen on the compare bus after the edge
    a_r2_addr_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel_e == SEL_ADDR_LO) |=> (brk_addr[REG_W-1:0] == $past(reg_wdata)));

    // R11: the status register reflects the flag driven by the controller
    a_r11_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_e == SEL_STATUS) |-> (reg_rdata == REG_W'(flag_q)));

endmodule

// File: rtl/brk_match.sv
module brk_match
    import brkcmp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_master,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [ADDR_W-1:0] brk_mask,
    input  cyc_sel_e          cyc_sel,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_ok;
    logic              addr_ok;
    logic              master_ok;

    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
            assign bit_ok[i] = brk_mask[i] | ~(bus_addr[i] ^ brk_addr[i]);
        end
    endgenerate

    assign addr_ok = &bit_ok;

    always_comb begin
        master_ok = 1'b0;
        unique case (cyc_sel)
            CYC_NONE: master_ok = 1'b0;
            CYC_CPU:  master_ok = (bus_master == MST_CPU);
            CYC_XFER: master_ok = (bus_master == MST_XFER);
            CYC_BOTH: master_ok = 1'b1;
        endcase
    end

    assign hit = bus_valid && addr_ok && master_ok;

    // R9: no hit without a valid access
    a_r9_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> !hit);

    // R5: a disabled cycle select never produces a hit
    a_r5_none_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_sel == CYC_NONE) |-> !hit);

    // R3: a fully masked address with both masters enabled always hits
    a_r3_full_mask_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (&brk_mask) && cyc_sel == CYC_BOTH) |-> hit);

endmodule

// File: rtl/brk_ctl.sv
module brk_ctl
    import brkcmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit,
    input  logic     clr_req,
    input  cyc_sel_e cyc_sel,
    output logic     flag_q,
    output logic     brk_irq
);
    brk_state_e state_q;
    brk_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (hit)                      state_d = ST_HELD;
                else if (cyc_sel != CYC_NONE) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (hit)                      state_d = ST_HELD;
                else if (cyc_sel == CYC_NONE) state_d = ST_OFF;
            end
            ST_HELD: begin
                if (!hit && clr_req)
                    state_d = (cyc_sel == CYC_NONE) ? ST_OFF : ST_WATCH;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_q  = (state_q == ST_HELD);
        brk_irq = flag_q;
    end

    // R10: a qualifying hit raises the request at the next edge
    a_r10_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> brk_irq);

    // R11: the request stays up until a clear is written
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_irq && !clr_req) |=> brk_irq);

    // R11: a clear with no concurrent hit drops the request
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !hit) |=> !brk_irq);

    // R12: a hit wins over a concurrent clear
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && hit) |=> brk_irq);

    // R5: without a hit the request cannot rise
    a_r5_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_irq && !hit) |=> !brk_irq);

endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brkcmp_pkg::*;
#(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_master,
    output logic              brk_irq
);
    logic [ADDR_W-1:0] brk_addr;
    logic [ADDR_W-1:0] brk_mask;
    cyc_sel_e          cyc_sel;
    logic              clr_req;
    logic              hit;
    logic              flag_q;

    brk_regfile #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .flag_q    (flag_q),
        .brk_addr  (brk_addr),
        .brk_mask  (brk_mask),
        .cyc_sel   (cyc_sel),
        .clr_req   (clr_req)
    );

    brk_match #(.ADDR_W(ADDR_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_master (bus_master),
        .brk_addr   (brk_addr),
        .brk_mask   (brk_mask),
        .cyc_sel    (cyc_sel),
        .hit        (hit)
    );

    brk_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_req (clr_req),
        .cyc_sel (cyc_sel),
        .flag_q  (flag_q),
        .brk_irq (brk_irq)
    );

endmodule

// File: tb/brk_unit_tb.sv
module brk_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_master = 1'b0;
    logic        brk_irq;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    brk_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_master(bus_master), .brk_irq(brk_irq)
    );

    typedef struct packed {
        logic [31:0] ba;
        logic [31:0] mk;
        logic [1:0]  sel;
        logic        mst;
        logic [31:0] addr;
        logic        exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5678, 32'h0000_0000, 2'b01, 1'b0, 32'h1234_5678, 1'b1}, // R6 exact cpu
        '{32'h1234_5678, 32'h0000_0000, 2'b01, 1'b0, 32'h1234_5679, 1'b0}, // R3 bit0 differs
        '{32'h1234_5678, 32'h0000_000F, 2'b01, 1'b0, 32'h1234_5670, 1'b1}, // R3 low mask
        '{32'h1234_5678, 32'hFFFF_0000, 2'b01, 1'b0, 32'hABCD_5678, 1'b1}, // R3 high mask
        '{32'h1234_5678, 32'hFFFF_0000, 2'b01, 1'b0, 32'hABCD_5670, 1'b0}, // R3 unmasked low bit differs
        '{32'h1234_5678, 32'h0000_0000, 2'b01, 1'b1, 32'h1234_5678, 1'b0}, // R6 xfer rejected
        '{32'h1234_5678, 32'h0000_0000, 2'b10, 1'b1, 32'h1234_5678, 1'b1}, // R7 xfer
        '{32'h1234_5678, 32'h0000_0000, 2'b10, 1'b0, 32'h1234_5678, 1'b0}, // R7 cpu rejected
        '{32'h1234_5678, 32'h0000_0000, 2'b11, 1'b0, 32'h1234_5678, 1'b1}, // R8 cpu
        '{32'h1234_5678, 32'h0000_0000, 2'b11, 1'b1, 32'h1234_5678, 1'b1}, // R8 xfer
        '{32'h1234_5678, 32'h0000_0000, 2'b00, 1'b0, 32'h1234_5678, 1'b0}, // R5 none
        '{32'h0000_0000, 32'hFFFF_FFFF, 2'b01, 1'b0, 32'hDEAD_BEEF, 1'b1}, // R3 all masked
        '{32'h8000_0000, 32'h7FFF_FFFF, 2'b11, 1'b0, 32'h0000_0000, 1'b0}  // R3 bit31 compared
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] s, input logic [15:0] exp, input string tag);
        reg_sel = s;
        #1;
        chk(tag, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    task automatic access(input logic [31:0] a, input logic m);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_master = m;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 8; s++) rd(3'(s), 16'h0000, "R1 reset readback");
        chk("R1 irq after reset", {31'h0, brk_irq}, 32'h0);

        // R3: after reset every bit compared (mask zero, address zero)
        wr(3'd4, 16'h0040);
        access(32'h0000_0001, 1'b0);
        chk("R3 reset mask, addr 1 no hit", {31'h0, brk_irq}, 32'h0);
        access(32'h0000_0000, 1'b0);
        chk("R3 reset mask, addr 0 hit", {31'h0, brk_irq}, 32'h1);
        wr(3'd5, 16'h0001);

        // R2: address readback
        wr(3'd0, 16'hA5C3);
        rd(3'd0, 16'hA5C3, "R2 addr high readback");
        wr(3'd1, 16'h3C5A);
        rd(3'd1, 16'h3C5A, "R2 addr low readback");
        wr(3'd2, 16'hF00F);
        rd(3'd2, 16'hF00F, "R3 mask high readback");
        wr(3'd3, 16'h0FF0);
        rd(3'd3, 16'h0FF0, "R3 mask low readback");

        // R4: reserved bits read zero
        wr(3'd4, 16'hFFFF);
        rd(3'd4, 16'h00C0, "R4 cycle reserved bits");
        wr(3'd4, 16'h0000);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VECS[i].ba[31:16]);
            wr(3'd1, VECS[i].ba[15:0]);
            wr(3'd2, VECS[i].mk[31:16]);
            wr(3'd3, VECS[i].mk[15:0]);
            wr(3'd4, {8'h00, VECS[i].sel, 6'h00});
            wr(3'd5, 16'h0001);
            chk($sformatf("vec %0d cleared before access", i), {31'h0, brk_irq}, 32'h0);
            access(VECS[i].addr, VECS[i].mst);
            chk($sformatf("vec %0d match result", i), {31'h0, brk_irq}, {31'h0, VECS[i].exp});
        end

        // Set up an exact CPU break at 0x0000_1000
        wr(3'd0, 16'h0000); wr(3'd1, 16'h1000);
        wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0040); wr(3'd5, 16'h0001);

        // R9: matching address without valid
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = 32'h0000_1000; bus_master = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 no valid no break", {31'h0, brk_irq}, 32'h0);

        // R10: low during the access cycle, high after the edge
        @(negedge clk);
        bus_valid = 1'b1;
        #1;
        chk("R10 low during access", {31'h0, brk_irq}, 32'h0);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R10 high after edge", {31'h0, brk_irq}, 32'h1);

        // R11: sticky, write 0 no effect, write 1 clears
        repeat (3) @(negedge clk);
        chk("R11 sticky", {31'h0, brk_irq}, 32'h1);
        wr(3'd5, 16'h0000);
        chk("R11 write 0 keeps flag", {31'h0, brk_irq}, 32'h1);
        rd(3'd5, 16'h0001, "R11 status reads flag");
        wr(3'd5, 16'h0001);
        chk("R11 write 1 clears", {31'h0, brk_irq}, 32'h0);
        rd(3'd5, 16'h0000, "R11 status reads cleared");

        // R12: hit and clear at the same edge
        access(32'h0000_1000, 1'b0);
        @(negedge clk);
        reg_sel = 3'd5; reg_we = 1'b1; reg_wdata = 16'h0001;
        bus_valid = 1'b1; bus_addr = 32'h0000_1000; bus_master = 1'b0;
        @(negedge clk);
        reg_we = 1'b0; bus_valid = 1'b0;
        chk("R12 hit wins over clear", {31'h0, brk_irq}, 32'h1);
        wr(3'd5, 16'h0001);
        chk("R12 later clear works", {31'h0, brk_irq}, 32'h0);

        finish_run();
    end

endmodule